// File: doc/BRIEF.md
# Capability Memory Access Checker

This block sits between an execution unit and a memory port. It handles loads and stores of one capability-sized granule at a time. Each request carries an authorising capability: a tag bit, a sealed flag, a permission field and an address. It also carries a 12-bit signed offset, a direction (load or store) and, for stores, the source capability. From these the block forms the effective address as the capability address plus the sign-extended offset. It then decides whether the access may proceed.

A legal request leaves the block one cycle later as a memory request. A request that breaks a rule produces a one-cycle fault pulse with a cause code, and nothing is sent to memory. Load responses come back from memory in request order. The block registers each one into a write-back result. The loaded tag survives only if the authorising capability held the capability-load permission. A small flag queue remembers that permission for every load still in flight.

Top module: `cap_access_checker`

## Requirements
- R1: A legal request appears on `mem_req` exactly one cycle after `in_valid`. `mem_addr` equals `cap_addr` plus the sign-extended `imm`, modulo 2^ADDR_W.
- R2: A request whose `cap_tag` is 0 faults with cause 1. This cause wins over every other cause.
- R3: A tagged request with `cap_sealed` = 1 faults with cause 2. This cause wins over causes 3 and 4.
- R4: A load needs permission bit 0 and a store needs permission bit 1. A tagged, unsealed request without its bit faults with cause 3, which wins over cause 4.
- R5: An effective address whose low log2(CAP_BYTES) bits are not zero faults with cause 4. Every address on `mem_addr` is granule-aligned.
- R6: A faulting request raises `flt_valid` for one cycle, one cycle after `in_valid`. It issues no memory request and produces no write-back. A legal request never raises `flt_valid`.
- R7: A legal store drives `mem_we` = 1 with `mem_wdata`/`mem_wtag` equal to the source capability. A later load of the same granule returns that data and tag.
- R8: For a load whose permission bit 2 (capability load) is set, `wb_valid` rises one cycle after `mem_rsp_valid`. `wb_data` and `wb_tag` then equal the memory response.
- R9: For a load whose permission bit 2 is clear, `wb_tag` is 0. `wb_data` still equals the memory data.
- R10: While `rst` is high and in the cycle after it, `mem_req`, `flt_valid` and `wb_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| in_is_store | input | 1 | 1 = store, 0 = load |
| cap_tag | input | 1 | Authorising capability validity tag |
| cap_sealed | input | 1 | Authorising capability is sealed |
| cap_perms | input | 3 | Permissions: bit0 load, bit1 store, bit2 capability load |
| cap_addr | input | ADDR_W | Authorising capability address |
| imm | input | 12 | Signed offset |
| st_data | input | DATA_W | Store source capability bits |
| st_tag | input | 1 | Store source capability tag |
| mem_req | output | 1 | Memory request strobe |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | ADDR_W | Effective address |
| mem_wdata | output | DATA_W | Write data |
| mem_wtag | output | 1 | Write tag |
| mem_rsp_valid | input | 1 | Load response present (in request order) |
| mem_rsp_data | input | DATA_W | Load response data |
| mem_rsp_tag | input | 1 | Load response tag |
| flt_valid | output | 1 | Fault pulse |
| flt_cause | output | 3 | Fault cause (1 untagged, 2 sealed, 3 permission, 4 misaligned) |
| wb_valid | output | 1 | Destination register write |
| wb_data | output | DATA_W | Destination data |
| wb_tag | output | 1 | Destination tag |

## Verification
The bench builds the block with ADDR_W = 16, DATA_W = 32, CAP_BYTES = 8 and FLAG_DEPTH = 2. The narrow address lets an offset carry the effective address past 0xFFFF and wrap around. The two-entry flag queue is filled completely by back-to-back loads, so simultaneous push and pop at full occupancy are exercised. The bench also stacks several fault conditions on one request to check which cause wins.

// File: rtl/cap_chk_pkg.sv
package cap_chk_pkg;
  localparam int PERM_W   = 3;
  localparam int PB_LOAD  = 0;
  localparam int PB_STORE = 1;
  localparam int PB_LDCAP = 2;
  localparam int CAUSE_W  = 3;
  localparam int IMM_W    = 12;

  typedef enum logic [CAUSE_W-1:0] {
    CZ_NONE     = 3'd0,
    CZ_UNTAGGED = 3'd1,
    CZ_SEALED   = 3'd2,
    CZ_PERM     = 3'd3,
    CZ_ALIGN    = 3'd4
  } cause_e;
endpackage

// File: rtl/cap_ea_gen.sv
module cap_ea_gen #(
  parameter int ADDR_W  = 32,
  parameter int ALIGN_W = 3
) (
  input  logic [ADDR_W-1:0]            base,
  input  logic [cap_chk_pkg::IMM_W-1:0] ofs,
  output logic [ADDR_W-1:0]            ea,
  output logic                         misaligned
);
  always_comb begin
    ea         = base + ADDR_W'($signed(ofs));
    misaligned = |ea[ALIGN_W-1:0];
  end
endmodule

// File: rtl/cap_fault_eval.sv
module cap_fault_eval
  import cap_chk_pkg::*;
(
  input  logic   tag,
  input  logic   sealed,
  input  logic   is_store,
  input  logic   perm_load,
  input  logic   perm_store,
  input  logic   misaligned,
  output cause_e cause
);
  logic need_ok;
  always_comb begin
    need_ok = is_store ? perm_store : perm_load;
    if (!tag)            cause = CZ_UNTAGGED;
    else if (sealed)     cause = CZ_SEALED;
    else if (!need_ok)   cause = CZ_PERM;
    else if (misaligned) cause = CZ_ALIGN;
    else                 cause = CZ_NONE;
  end
endmodule

// File: rtl/cap_flag_fifo.sv
module cap_flag_fifo #(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic push,
  input  logic din,
  input  logic pop,
  output logic dout
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = PTR_W + 1;

  logic             store_q [DEPTH];
  logic [PTR_W-1:0] wptr, rptr;
  logic [CNT_W-1:0] count;

  always_ff @(posedge clk) begin
    if (push) store_q[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push) wptr <= (wptr == PTR_W'(DEPTH-1)) ? '0 : wptr + 1'b1;
      if (pop)  rptr <= (rptr == PTR_W'(DEPTH-1)) ? '0 : rptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign dout = store_q[rptr];

  // R8: in-flight load permissions never exceed the queue
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (push && !pop) |-> (count < CNT_W'(DEPTH)));
  // R8: a response always has a recorded permission
  a_r8_no_underflow: assert property (@(posedge clk) disable iff (rst)
    pop |-> (count != '0));
endmodule

// File: rtl/cap_access_checker.sv
module cap_access_checker
  import cap_chk_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 64,
  parameter int CAP_BYTES  = 8,
  parameter int FLAG_DEPTH = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic                in_is_store,
  input  logic                cap_tag,
  input  logic                cap_sealed,
  input  logic [2:0]          cap_perms,
  input  logic [ADDR_W-1:0]   cap_addr,
  input  logic [11:0]         imm,
  input  logic [DATA_W-1:0]   st_data,
  input  logic                st_tag,
  output logic                mem_req,
  output logic                mem_we,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]   mem_wdata,
  output logic                mem_wtag,
  input  logic                mem_rsp_valid,
  input  logic [DATA_W-1:0]   mem_rsp_data,
  input  logic                mem_rsp_tag,
  output logic                flt_valid,
  output logic [2:0]          flt_cause,
  output logic                wb_valid,
  output logic [DATA_W-1:0]   wb_data,
  output logic                wb_tag
);
  localparam int ALIGN_W = $clog2(CAP_BYTES);

  logic [ADDR_W-1:0] ea;
  logic              misaligned;
  cause_e            cause;
  logic              legal;
  logic              ld_push;
  logic              ldcap_ok;

  cap_ea_gen #(.ADDR_W(ADDR_W), .ALIGN_W(ALIGN_W)) u_ea (
    .base(cap_addr), .ofs(imm), .ea(ea), .misaligned(misaligned)
  );

  cap_fault_eval u_fe (
    .tag(cap_tag), .sealed(cap_sealed), .is_store(in_is_store),
    .perm_load(cap_perms[PB_LOAD]), .perm_store(cap_perms[PB_STORE]),
    .misaligned(misaligned), .cause(cause)
  );

  assign legal   = in_valid && (cause == CZ_NONE);
  assign ld_push = legal && !in_is_store;

  cap_flag_fifo #(.DEPTH(FLAG_DEPTH)) u_ff (
    .clk(clk), .rst(rst), .push(ld_push), .din(cap_perms[PB_LDCAP]),
    .pop(mem_rsp_valid), .dout(ldcap_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req   <= 1'b0;
      flt_valid <= 1'b0;
      wb_valid  <= 1'b0;
    end else begin
      mem_req   <= legal;
      flt_valid <= in_valid && (cause != CZ_NONE);
      wb_valid  <= mem_rsp_valid;
    end
  end

  always_ff @(posedge clk) begin
    mem_we    <= in_is_store;
    mem_addr  <= ea;
    mem_wdata <= st_data;
    mem_wtag  <= st_tag;
    flt_cause <= cause;
    wb_data   <= mem_rsp_data;
    wb_tag    <= mem_rsp_tag & ldcap_ok;
  end

  // R10: outputs quiet right after reset
  a_r10_reset_quiet: assert property (@(posedge clk)
    rst |=> (!mem_req && !flt_valid && !wb_valid));
  // R6: a fault and a memory request are never issued together
  a_r6_no_req_on_fault: assert property (@(posedge clk) disable iff (rst)
    !(flt_valid && mem_req));
  // R1: request address follows the operands of the previous cycle
  a_r1_ea: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr == $past(cap_addr + ADDR_W'($signed(imm)))));
  // R5: memory only ever sees granule-aligned addresses
  a_r5_aligned: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr[ALIGN_W-1:0] == '0));
  // R2: a fault always carries a non-zero cause
  a_r2_cause_set: assert property (@(posedge clk) disable iff (rst)
    flt_valid |-> (flt_cause != 3'd0));
  // R9: a set destination tag needs a set memory tag
  a_r9_tag_source: assert property (@(posedge clk) disable iff (rst)
    (wb_valid && wb_tag) |-> $past(mem_rsp_tag));
  // R8: write-back only follows a memory response
  a_r8_wb_follows_rsp: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> $past(mem_rsp_valid));
endmodule

// File: tb/sim_cap_access_checker.sv
module sim_cap_access_checker;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int CB = 8;
  localparam int FD = 2;
  localparam int AL = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_is_store = 1'b0, cap_tag = 1'b0, cap_sealed = 1'b0;
  logic [2:0] cap_perms = '0;
  logic [AW-1:0] cap_addr = '0;
  logic [11:0] imm = '0;
  logic [DW-1:0] st_data = '0;
  logic st_tag = 1'b0;
  logic mem_req, mem_we, mem_wtag, flt_valid, wb_valid, wb_tag;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, wb_data;
  logic [2:0] flt_cause;
  logic mem_rsp_valid, mem_rsp_tag;
  logic [DW-1:0] mem_rsp_data;

  always #5 clk = ~clk;

  cap_access_checker #(.ADDR_W(AW), .DATA_W(DW), .CAP_BYTES(CB), .FLAG_DEPTH(FD)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_is_store(in_is_store),
    .cap_tag(cap_tag), .cap_sealed(cap_sealed), .cap_perms(cap_perms),
    .cap_addr(cap_addr), .imm(imm), .st_data(st_data), .st_tag(st_tag),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_wtag(mem_wtag), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .mem_rsp_tag(mem_rsp_tag),
    .flt_valid(flt_valid), .flt_cause(flt_cause), .wb_valid(wb_valid),
    .wb_data(wb_data), .wb_tag(wb_tag)
  );

  // tagged memory model: 16 granules, one-cycle read latency
  logic [DW-1:0] mdat [16];
  logic          mtag [16];
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 16; i++) begin mdat[i] <= '0; mtag[i] <= 1'b0; end
      mem_rsp_valid <= 1'b0;
      mem_rsp_data  <= '0;
      mem_rsp_tag   <= 1'b0;
    end else begin
      mem_rsp_valid <= mem_req && !mem_we;
      mem_rsp_data  <= mdat[mem_addr[AL+3:AL]];
      mem_rsp_tag   <= mtag[mem_addr[AL+3:AL]];
      if (mem_req && mem_we) begin
        mdat[mem_addr[AL+3:AL]] <= mem_wdata;
        mtag[mem_addr[AL+3:AL]] <= mem_wtag;
      end
    end
  end

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // scoreboard queues
  logic [2:0]          q_flt [$];
  string               q_flt_r [$];
  logic [AW+DW+1:0]    q_req [$];
  string               q_req_r [$];
  logic [DW:0]         q_wb [$];
  string               q_wb_r [$];

  logic [DW-1:0] sh_dat [16];
  logic          sh_tag [16];

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // driver: compute expectation, push, drive one cycle
  task automatic issue(string req, bit st, bit tg, bit sl, logic [2:0] pm,
                       logic [AW-1:0] a, logic [11:0] im, logic [DW-1:0] d, bit dt);
    logic [AW-1:0] ea;
    logic [2:0] c;
    int g;
    ea = a + AW'($signed(im));
    g  = int'(ea[AL+3:AL]);
    if (!tg) c = 3'd1;
    else if (sl) c = 3'd2;
    else if (!(st ? pm[1] : pm[0])) c = 3'd3;
    else if (ea[AL-1:0] != '0) c = 3'd4;
    else c = 3'd0;
    if (c != 3'd0) begin
      q_flt.push_back(c); q_flt_r.push_back(req);
    end else begin
      q_req.push_back({st, ea, (st ? d : {DW{1'b0}}), (st ? dt : 1'b0)});
      q_req_r.push_back(req);
      if (st) begin sh_dat[g] = d; sh_tag[g] = dt; end
      else begin q_wb.push_back({sh_dat[g], sh_tag[g] & pm[2]}); q_wb_r.push_back(req); end
    end
    in_valid = 1; in_is_store = st; cap_tag = tg; cap_sealed = sl; cap_perms = pm;
    cap_addr = a; imm = im; st_data = d; st_tag = dt;
    @(negedge clk);
    in_valid = 0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (flt_valid) begin
        if (q_flt.size() == 0) chk("R6 unexpected fault", 64'(flt_cause), 64'hdead);
        else begin
          chk({q_flt_r[0], " cause"}, 64'(flt_cause), 64'(q_flt[0]));
          void'(q_flt.pop_front()); void'(q_flt_r.pop_front());
        end
      end
      if (mem_req) begin
        if (q_req.size() == 0) chk("R6 unexpected mem_req", 64'(mem_addr), 64'hdead);
        else begin
          chk({q_req_r[0], " request"},
              64'({mem_we, mem_addr, (mem_we ? mem_wdata : {DW{1'b0}}), (mem_we ? mem_wtag : 1'b0)}),
              64'(q_req[0]));
          void'(q_req.pop_front()); void'(q_req_r.pop_front());
        end
      end
      if (wb_valid) begin
        if (q_wb.size() == 0) chk("R6 unexpected write-back", 64'(wb_data), 64'hdead);
        else begin
          chk({q_wb_r[0], " write-back"}, 64'({wb_data, wb_tag}), 64'(q_wb[0]));
          void'(q_wb.pop_front()); void'(q_wb_r.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL R6 watchdog actual=timeout expected=completion");
    report();
  end

  initial begin
    for (int i = 0; i < 16; i++) begin sh_dat[i] = '0; sh_tag[i] = 1'b0; end
    repeat (3) @(negedge clk);
    chk("R10 reset mem_req", 64'(mem_req), 0);
    chk("R10 reset flt_valid", 64'(flt_valid), 0);
    chk("R10 reset wb_valid", 64'(wb_valid), 0);
    rst = 0;
    @(negedge clk);
    chk("R10 post-reset quiet", 64'({mem_req, flt_valid, wb_valid}), 0);

    issue("R1 R7 store +8",      1, 1, 0, 3'b011, 16'h0100, 12'h008, 32'hCAFE0001, 1);
    issue("R8 load ldcap",       0, 1, 0, 3'b111, 16'h0100, 12'h008, 0, 0);
    issue("R9 load no ldcap",    0, 1, 0, 3'b001, 16'h0108, 12'h000, 0, 0);
    issue("R8 load back-to-back",0, 1, 0, 3'b101, 16'h0110, 12'hFF8, 0, 0);
    issue("R7 store untagged",   1, 1, 0, 3'b010, 16'h0120, 12'hFF0, 32'h12345678, 0);
    issue("R8 load untagged mem",0, 1, 0, 3'b111, 16'h0110, 12'h000, 0, 0);
    issue("R1 wrap store",       1, 1, 0, 3'b010, 16'hFFF8, 12'h010, 32'hA5A5A5A5, 1);
    issue("R1 R8 wrap load",     0, 1, 0, 3'b111, 16'h0000, 12'h008, 0, 0);
    issue("R2 untagged load",    0, 0, 0, 3'b111, 16'h0200, 12'h000, 0, 0);
    issue("R2 untagged sealed misaligned", 1, 0, 1, 3'b000, 16'h0201, 12'h000, 32'h1, 1);
    issue("R3 sealed load",      0, 1, 1, 3'b111, 16'h0200, 12'h000, 0, 0);
    issue("R3 sealed noperm misaligned", 1, 1, 1, 3'b000, 16'h0203, 12'h000, 32'h1, 1);
    issue("R4 load no load perm",0, 1, 0, 3'b110, 16'h0200, 12'h000, 0, 0);
    issue("R4 store no store perm misaligned", 1, 1, 0, 3'b101, 16'h0204, 12'h000, 32'h2, 1);
    issue("R5 misaligned imm",   0, 1, 0, 3'b111, 16'h0200, 12'h004, 0, 0);
    issue("R5 misaligned neg",   1, 1, 0, 3'b011, 16'h0200, 12'hFFF, 32'h3, 1);
    issue("R6 faulting store",   1, 1, 1, 3'b011, 16'h0108, 12'h000, 32'hBADBAD00, 0);
    issue("R6 R8 granule intact",0, 1, 0, 3'b111, 16'h0108, 12'h000, 0, 0);
    repeat (5) @(negedge clk);
    chk("R6 fault queue drained", 64'(q_flt.size()), 0);
    chk("R6 request queue drained", 64'(q_req.size()), 0);
    chk("R8 write-back queue drained", 64'(q_wb.size()), 0);
    report();
  end
endmodule